// File: doc/BRIEF.md
# SPI Master with Transmit and Receive FIFOs

This block is an SPI master with FIFOs on both sides. Bytes written into an 8-entry transmit queue are shifted out on MOSI, most significant bit first, while the block drives SCLK in SPI mode 0. At the same time MISO is sampled, and each completed byte is stored in an 8-entry receive queue. Both queues have a plain strobe-based port, and software sees full and empty flags for each. The SCLK rate comes from the system clock through a programmable half-period count. While the transmit queue holds data, bytes follow each other with no idle time between them.

Three active-low select lines address the slave. In line mode, exactly one of them goes low during a transfer. In code mode, the same three lines carry a 3-bit slave number for an external 3-to-8 decoder, and the idle value is all ones. A transfer starts in one of two ways. In automatic mode it starts as soon as the transmit queue is not empty. In manual mode it starts on a one-cycle start pulse. Once a transfer has started, it ends only when the transmit queue has drained. A busy output covers the time from the first SCLK edge until the select is released.

Top module: `spi_fifo_master`

## Requirements
- R1: SCLK is low whenever no slave is selected. MOSI changes only at SCLK falling edges, or before the first rising edge. Each byte is sent MSB first, and MISO is sampled at SCLK rising edges.
- R2: One SCLK half period lasts `div_half` system clocks, with 0 treated as 1. The first rising edge comes `div_half` clocks after the select line asserts.
- R3: With `ss_encoded`=0, line `ss_n[ss_sel]` is driven low during a transfer and the other lines stay high. At most one line is ever low, and the idle value is 3'b111. `ss_sel` must be 0 to 2.
- R4: With `ss_encoded`=1, `ss_n` carries the value of `ss_sel` (0 to 6) during a transfer and 3'b111 when idle.
- R5: With `auto_mode`=1, an idle engine starts a transfer as soon as the transmit queue is not empty, with no start pulse.
- R6: With `auto_mode`=0, a transfer starts only on a `start` pulse while the transmit queue is not empty. A pulse while the queue is empty has no effect.
- R7: While the transmit queue is not empty, the next byte follows with no gap. Successive SCLK rising edges within one select period are always 2*`div_half` clocks apart.
- R8: Every completed 8-bit receive is pushed into the receive queue, with the first MISO bit as the MSB. Sending n bytes yields n received bytes. `rx_data` shows the oldest entry, and `rx_rd` removes it.
- R9: The select line releases `div_half` clocks after the final SCLK falling edge, once the transmit queue is empty.
- R10: Each queue holds 8 bytes and reports full and empty flags. A write to a full transmit queue is discarded.
- R11: If a byte completes while the receive queue is full, the byte is discarded and `rx_ovf` is set. `rx_ovf` stays set until reset.
- R12: `busy` is low before the first SCLK rising edge of a select period. It is high from that edge on, and drops in the same cycle that the select releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_half | input | 8 | SCLK half period in system clocks |
| auto_mode | input | 1 | 1: start when data is queued; 0: start on pulse |
| ss_encoded | input | 1 | 1: select lines carry a code; 0: one line per slave |
| ss_sel | input | 3 | Slave index or code |
| start | input | 1 | Manual start pulse |
| tx_wr | input | 1 | Transmit queue write strobe |
| tx_data | input | 8 | Byte to queue |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_rd | input | 1 | Receive queue read strobe |
| rx_data | output | 8 | Oldest received byte |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_ovf | output | 1 | Sticky receive overflow flag |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 3 | Active-low selects, or select code |
| busy | output | 1 | Transfer in progress |

## Verification
The assertions assume that `div_half`, `auto_mode`, `ss_encoded` and `ss_sel` stay fixed while a slave is selected. They also assume that `ss_sel` stays within 0 to 2 in line mode and 0 to 6 in code mode, and that `start` is a single-cycle pulse. The stimulus sets all of these only while the select lines are idle. It draws slave numbers from the legal range for the chosen mode and keeps half periods between 1 and 4 clocks. The slave model changes MISO right after each rising edge, so the value is steady when the next rising edge samples it.

// File: rtl/spi_pkg.sv
package spi_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_XFER = 2'd1,
      ST_HOLD = 2'd2
   } spi_state_e;
endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         rd,
   output logic [W-1:0] rdata,
   output logic         full,
   output logic         empty
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("spi_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;
   logic          wr_ok, rd_ok;

   assign full  = (cnt == (AW+1)'(DEPTH));
   assign empty = (cnt == '0);
   assign wr_ok = wr && !full;
   assign rd_ok = rd && !empty;
   assign rdata = mem[rp];

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (wr_ok) wp <= wp + 1'b1;
         if (rd_ok) rp <= rp + 1'b1;
         case ({wr_ok, rd_ok})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr && !rd) |=> (cnt == $past(cnt)))
      else $error("write into full queue changed occupancy"); // R10

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= (AW+1)'(DEPTH))
      else $error("queue occupancy above depth"); // R10
endmodule

// File: rtl/spi_engine.sv
module spi_engine
   import spi_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  div_half,
   input  logic              auto_mode,
   input  logic              start,
   input  logic              tx_empty,
   input  logic [DATA_W-1:0] tx_dout,
   output logic              tx_pop,
   output logic              rx_push,
   output logic [DATA_W-1:0] rx_byte,
   input  logic              miso,
   output logic              sclk,
   output logic              mosi,
   output logic              cs_act,
   output logic              busy
);
   localparam int BIT_W = $clog2(DATA_W);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

   generate
      if (DATA_W < 2 || DIV_W < 1) begin : g_bad_cfg
         $error("spi_engine: DATA_W must be at least 2 and DIV_W at least 1");
      end
   endgenerate

   spi_state_e        state;
   logic [DIV_W-1:0]  cnt, half_eff;
   logic [BIT_W-1:0]  bits;
   logic [DATA_W-1:0] tx_sh, rx_sh;
   logic              tick, go, last_fall;

   assign half_eff  = (div_half == '0) ? DIV_W'(1) : div_half;
   assign tick      = (cnt == half_eff - DIV_W'(1));
   assign go        = !tx_empty && (auto_mode || start);
   assign last_fall = (state == ST_XFER) && tick && sclk && (bits == LAST_BIT);
   assign tx_pop    = ((state == ST_IDLE) && go) || (last_fall && !tx_empty);
   assign rx_push   = last_fall;
   assign rx_byte   = rx_sh;
   assign mosi      = tx_sh[DATA_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         bits   <= '0;
         tx_sh  <= '0;
         rx_sh  <= '0;
         sclk   <= 1'b0;
         cs_act <= 1'b0;
         busy   <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               cnt  <= '0;
               sclk <= 1'b0;
               if (go) begin
                  tx_sh  <= tx_dout;
                  bits   <= '0;
                  cs_act <= 1'b1;
                  state  <= ST_XFER;
               end
            end
            ST_XFER: begin
               cnt <= tick ? '0 : cnt + 1'b1;
               if (tick && !sclk) begin
                  sclk  <= 1'b1;
                  busy  <= 1'b1;
                  rx_sh <= {rx_sh[DATA_W-2:0], miso};
               end else if (tick && sclk) begin
                  sclk <= 1'b0;
                  if (bits == LAST_BIT) begin
                     if (!tx_empty) begin
                        tx_sh <= tx_dout;
                        bits  <= '0;
                     end else begin
                        state <= ST_HOLD;
                     end
                  end else begin
                     tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                     bits  <= bits + 1'b1;
                  end
               end
            end
            ST_HOLD: begin
               cnt <= tick ? '0 : cnt + 1'b1;
               if (tick) begin
                  cs_act <= 1'b0;
                  busy   <= 1'b0;
                  state  <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |-> !sclk)
      else $error("SCLK high with no slave selected"); // R1

   AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi))
      else $error("MOSI moved while SCLK high"); // R1

   AST_BUSY_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> cs_act)
      else $error("busy without an active select"); // R12

   AST_PUSH_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |=> !sclk)
      else $error("receive push not at a falling edge"); // R8
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8,
   parameter int DIV_W  = 8,
   parameter int NUM_SS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  div_half,
   input  logic              auto_mode,
   input  logic              ss_encoded,
   input  logic [NUM_SS-1:0] ss_sel,
   input  logic              start,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_full,
   output logic              tx_empty,
   input  logic              rx_rd,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              rx_empty,
   output logic              rx_ovf,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic [NUM_SS-1:0] ss_n,
   output logic              busy
);
   generate
      if (NUM_SS < 2) begin : g_bad_ss
         $error("spi_fifo_master: NUM_SS must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] tx_dout, rx_byte;
   logic              tx_pop, rx_push, cs_act;
   logic [NUM_SS-1:0] line_n, code_n;

   spi_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .wr(tx_wr), .wdata(tx_data), .rd(tx_pop),
      .rdata(tx_dout), .full(tx_full), .empty(tx_empty)
   );

   spi_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .wr(rx_push), .wdata(rx_byte), .rd(rx_rd),
      .rdata(rx_data), .full(rx_full), .empty(rx_empty)
   );

   spi_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .div_half(div_half), .auto_mode(auto_mode),
      .start(start), .tx_empty(tx_empty), .tx_dout(tx_dout), .tx_pop(tx_pop),
      .rx_push(rx_push), .rx_byte(rx_byte), .miso(miso), .sclk(sclk),
      .mosi(mosi), .cs_act(cs_act), .busy(busy)
   );

   for (genvar i = 0; i < NUM_SS; i++) begin : g_line
      assign line_n[i] = !(cs_act && (ss_sel == NUM_SS'(i)));
   end

   assign code_n = cs_act ? ss_sel : '1;
   assign ss_n   = ss_encoded ? code_n : line_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_ovf <= 1'b0;
      else if (rx_push && rx_full) rx_ovf <= 1'b1;
   end

   AST_SS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      !ss_encoded |-> $onehot0(~ss_n))
      else $error("more than one select line low"); // R3

   AST_SS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !sclk && $past(!cs_act) && !cs_act |-> (ss_n == '1))
      else $error("select lines not idle"); // R4

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rx_ovf) |-> rx_ovf)
      else $error("overflow flag cleared"); // R11
endmodule

// File: tb/tb_spi_fifo_master.sv
module tb_spi_fifo_master;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] div_half = 8'd1;
   logic       auto_mode = 1'b0, ss_encoded = 1'b0, start = 1'b0;
   logic [2:0] ss_sel = 3'd0;
   logic       tx_wr = 1'b0, rx_rd = 1'b0, miso = 1'b0;
   logic [7:0] tx_data = 8'd0;
   logic       tx_full, tx_empty, rx_full, rx_empty, rx_ovf, sclk, mosi, busy;
   logic [7:0] rx_data;
   logic [2:0] ss_n;

   spi_fifo_master dut (
      .clk(clk), .rst_n(rst_n), .div_half(div_half), .auto_mode(auto_mode),
      .ss_encoded(ss_encoded), .ss_sel(ss_sel), .start(start), .tx_wr(tx_wr),
      .tx_data(tx_data), .tx_full(tx_full), .tx_empty(tx_empty), .rx_rd(rx_rd),
      .rx_data(rx_data), .rx_full(rx_full), .rx_empty(rx_empty), .rx_ovf(rx_ovf),
      .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n), .busy(busy)
   );

   always #5 clk = ~clk;

   int checks = 0, errors = 0;
   bit done = 0;
   int cyc = 0, ncap = 0, rises = 0, t_sel = 0, t_rise = 0, t_fall = 0;
   logic [7:0] cap [32];
   logic [7:0] sent [16];
   logic [7:0] shv = 8'd0;
   logic p_sclk = 0, p_act = 0, p_mosi = 0;

   function automatic logic [7:0] reply(input int k);
      return 8'(k * 37 + 11);
   endfunction

   function automatic logic [2:0] exp_ss();
      return ss_encoded ? ss_sel : ~(3'b001 << ss_sel);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // slave model and edge monitor, sampled away from the active edge
   always @(negedge clk) begin
      logic act;
      logic [7:0] r;
      cyc++;
      act = (ss_n != 3'b111);
      if (rst_n) begin
         if (act && !p_act) begin
            t_sel = cyc; rises = 0;
            chk(!busy, "R12 busy before first edge", busy, 0);
         end
         if (sclk && !p_sclk) begin
            if (rises == 0) chk(cyc - t_sel == int'(div_half), "R2 first edge delay", cyc - t_sel, div_half);
            else chk(cyc - t_rise == 2 * int'(div_half), "R7 edge spacing", cyc - t_rise, 2 * div_half);
            t_rise = cyc;
            chk(busy, "R12 busy at edge", busy, 1);
            chk(ss_n == exp_ss(), ss_encoded ? "R4 select code" : "R3 select line", ss_n, exp_ss());
            shv = {shv[6:0], mosi};
            rises++;
            if (rises % 8 == 0) begin cap[ncap % 32] = shv; ncap++; end
         end
         if (sclk && p_sclk && mosi != p_mosi) chk(0, "R1 MOSI moved while SCLK high", mosi, p_mosi);
         if (!sclk && p_sclk) t_fall = cyc;
         if (!act && p_act) begin
            chk(cyc - t_fall == int'(div_half), "R9 select release delay", cyc - t_fall, div_half);
            chk(!busy, "R12 busy after release", busy, 0);
         end
      end
      r = reply(ncap);
      miso = r[7 - (rises % 8)];
      p_sclk = sclk; p_act = act; p_mosi = mosi;
   end

   task automatic cfg(input int h, input bit au, input bit en, input int sel);
      @(negedge clk);
      div_half = 8'(h); auto_mode = au; ss_encoded = en; ss_sel = 3'(sel);
   endtask

   task automatic push_tx(input logic [7:0] d);
      @(negedge clk); tx_data = d; tx_wr = 1'b1;
      @(negedge clk); tx_wr = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic wait_done(input int target);
      while (ncap < target) @(negedge clk);
      while (ss_n != 3'b111) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic check_bytes(input int base, input int n);
      for (int i = 0; i < n; i++)
         chk(cap[(base + i) % 32] == sent[i], "R1 MOSI byte", cap[(base + i) % 32], sent[i]);
   endtask

   task automatic drain_rx(input int base, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(!rx_empty && rx_data == reply(base + i), "R8 received byte", rx_data, reply(base + i));
         rx_rd = 1'b1;
         @(negedge clk); rx_rd = 1'b0;
      end
      @(negedge clk);
      chk(rx_empty, "R8 byte count", rx_empty, 1);
   endtask

   task automatic burst(input int n, input int h, input bit au, input bit en, input int sel, input bit rd);
      int base;
      cfg(h, au, en, sel);
      base = ncap;
      for (int i = 0; i < n; i++) push_tx(sent[i]);
      if (!au) pulse_start();
      wait_done(base + n);
      chk(ncap - base == n, "R8 bytes per burst", ncap - base, n);
      chk(tx_empty, "R10 tx drained", tx_empty, 1);
      check_bytes(base, n);
      if (rd) drain_rx(base, n);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=0", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int base, n;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk(ss_n == 3'b111 && !sclk && !busy, "R3 idle after reset", {ss_n, sclk, busy}, 5'b11100);
      chk(tx_empty && rx_empty && !tx_full && !rx_full, "R10 flags after reset",
          {tx_empty, rx_empty, tx_full, rx_full}, 4'b1100);
      chk(!rx_ovf, "R11 overflow clear after reset", rx_ovf, 0);

      // R6: start with empty queue has no effect
      cfg(2, 0, 0, 1);
      base = ncap;
      pulse_start();
      repeat (30) @(negedge clk);
      chk(ss_n == 3'b111 && ncap == base, "R6 start on empty queue", ss_n, 7);
      // R6: queued data without start stays put
      sent[0] = 8'hA5;
      push_tx(sent[0]);
      repeat (30) @(negedge clk);
      chk(ss_n == 3'b111 && !tx_empty, "R6 no start pulse", ss_n, 7);
      pulse_start();
      wait_done(base + 1);
      check_bytes(base, 1);
      drain_rx(base, 1);

      // R5: automatic start, directed
      sent[0] = 8'h81; sent[1] = 8'h7E;
      burst(2, 1, 1, 0, 2, 1);
      // R4: code mode, slave 5
      sent[0] = 8'h3C; sent[1] = 8'hC3; sent[2] = 8'h01;
      burst(3, 3, 1, 1, 5, 1);

      // R10: ninth write into full queue is dropped
      cfg(1, 0, 0, 0);
      base = ncap;
      for (int i = 0; i < 9; i++) begin
         sent[i] = 8'(8'h10 + i * 3);
         push_tx(sent[i]);
         if (i == 7) chk(tx_full, "R10 tx full after eight", tx_full, 1);
      end
      chk(tx_full, "R10 tx full after drop", tx_full, 1);
      pulse_start();
      wait_done(base + 8);
      repeat (20) @(negedge clk);
      chk(ncap - base == 8 && tx_empty, "R10 dropped write", ncap - base, 8);
      check_bytes(base, 8);
      drain_rx(base, 8);

      // R11: overflow when the receive queue is full
      for (int i = 0; i < 8; i++) sent[i] = 8'($urandom);
      base = ncap;
      burst(8, 2, 1, 0, 1, 0);
      chk(rx_full && !rx_ovf, "R10 rx full no overflow", {rx_full, rx_ovf}, 2'b10);
      sent[0] = 8'h55;
      burst(1, 1, 1, 0, 0, 0);
      chk(rx_ovf, "R11 overflow set", rx_ovf, 1);
      drain_rx(base, 8);

      // constrained random bursts
      for (int k = 0; k < 14; k++) begin
         bit en, au;
         int sel;
         n = 1 + $urandom % 8;
         en = 1'($urandom % 2);
         au = 1'($urandom % 2);
         sel = en ? int'($urandom % 7) : int'($urandom % 3);
         for (int i = 0; i < n; i++) sent[i] = 8'($urandom);
         burst(n, 1 + $urandom % 4, au, en, sel, 1);
      end
      chk(rx_ovf, "R11 overflow sticky", rx_ovf, 1);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule